// File: doc/BRIEF.md
# DMA Page-Extended Address Generator

This block produces the 24-bit physical bus address and the remaining-transfer count for a single DMA channel. The address is built from an 8-bit page value, which stays fixed for the whole operation, and a 16-bit current-address counter that steps once for every accepted transfer strobe. A load pulse sets up a new operation. It latches the page, the starting address, the count (transfers minus one), the channel width, the stepping direction and the auto-initialise option.

A byte-wide channel places the counter directly under the page, so each step moves one byte inside a fixed 64 KiB window. A word-wide channel shifts the counter up by one bit and drops page bit 0. Each step then moves one 16-bit word inside a fixed 128 KiB window, and address bit 0 is always zero. When the counter wraps, the page does not carry, so a transfer can never leave its window.

When the count passes from zero to all-ones, the block raises a one-cycle terminal-count pulse. What follows depends on the auto-initialise option. With the option set, the address and count reload from the values of the last load. Without it, the channel stops accepting strobes until the next load. A residue output gives the number of bytes still to move, scaled by the channel width.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After reset the bus address is 0x000000, the count is 0x0000, the terminal-count and finished flags are low, the channel is byte-wide, and the residue reads 1.
- R2: A byte-wide channel (load_word_i=0) drives bus_addr_o = {page[7:0], counter[15:0]}.
- R3: A word-wide channel (load_word_i=1) drives bus_addr_o = {page[7:1], counter[15:0], 1'b0}, so page bit 0 has no effect and bit 0 of the address is zero.
- R4: Each accepted strobe moves the counter by exactly one. It counts up when load_down_i was 0 at load and down when it was 1.
- R5: When the 16-bit counter wraps in either direction, the page bits of bus_addr_o stay unchanged.
- R6: Each accepted strobe lowers the count by one. The strobe that finds the count at 0x0000 makes tc_o high in the following cycle, and for that one cycle only.
- R7: Without auto-initialise, that terminating strobe leaves the count at 0xFFFF and raises done_o. Later strobes change neither the address nor the count and raise no tc_o, until the next load.
- R8: With auto-initialise (load_auto_i=1), the terminating strobe reloads the address and the count from the last load. It still pulses tc_o, and done_o stays low.
- R9: A load latches the page, the address, the count and the mode bits, and clears tc_o and done_o. A strobe in the same cycle as a load is ignored.
- R10: residue_o is count+1 for a byte channel and (count+1)×2 for a word channel, and it reads 0 while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Latch a new operation from the load_* inputs |
| load_page_i | input | 8 | Page value (address bits above the counter) |
| load_addr_i | input | 16 | Starting counter value |
| load_count_i | input | 16 | Transfers minus one |
| load_word_i | input | 1 | 1 = word-wide channel, 0 = byte-wide |
| load_down_i | input | 1 | 1 = counter steps down, 0 = up |
| load_auto_i | input | 1 | 1 = reload the address and count at terminal count |
| xfer_i | input | 1 | Transfer strobe, one step per high cycle |
| bus_addr_o | output | 24 | Physical bus address |
| count_o | output | 16 | Current count register |
| residue_o | output | 18 | Bytes still to transfer |
| tc_o | output | 1 | One-cycle terminal-count pulse |
| done_o | output | 1 | Operation finished, strobes are ignored |

## Verification
The embedded assertions hold on every cycle for four behaviours. The page bits stay constant across strobes, including wraps. The counter moves by exactly one step in the direction latched at load. Every tc_o pulse traces back to an accepted strobe at count zero. A finished channel keeps its count frozen. Only the bench scenarios can show the exact address values for each mapping and the auto-initialise reload targets. The same goes for a load winning over a simultaneous strobe and for the residue scaling at full count.

// File: rtl/dma_pag_pkg.sv
package dma_pag_pkg;
    localparam int unsigned DMA_PAGE_W = 8;
    localparam int unsigned DMA_CNT_W  = 16;

    typedef enum logic {
        XW_BYTE = 1'b0,
        XW_WORD = 1'b1
    } xfer_width_e;

    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;
endpackage

// File: rtl/dma_addr_counter.sv
module dma_addr_counter
    import dma_pag_pkg::*;
#(
    parameter int unsigned CNT_W = DMA_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_addr_i,
    input  logic             load_down_i,
    input  logic             step_i,
    input  logic             reload_i,
    output logic [CNT_W-1:0] addr_o
);
    typedef struct packed {
        logic [CNT_W-1:0] addr;
        logic [CNT_W-1:0] base;
        step_dir_e        dir;
    } acnt_t;

    acnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.addr = load_addr_i;
            st_d.base = load_addr_i;
            st_d.dir  = step_dir_e'(load_down_i);
        end else if (step_i) begin
            if (reload_i) begin
                st_d.addr = st_q.base;
            end else if (st_q.dir == STEP_DOWN) begin
                st_d.addr = st_q.addr - 1'b1;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, base: '0, dir: STEP_UP};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;

    // R4: single-step movement in the latched direction
    a_r4_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !reload_i && !load_i && st_q.dir == STEP_UP)
        |=> addr_o == $past(addr_o) + 1'b1);
    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !reload_i && !load_i && st_q.dir == STEP_DOWN)
        |=> addr_o == $past(addr_o) - 1'b1);
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit
    import dma_pag_pkg::*;
#(
    parameter int unsigned CNT_W = DMA_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_count_i,
    input  logic             load_auto_i,
    input  logic             xfer_i,
    output logic [CNT_W-1:0] count_o,
    output logic             accept_o,
    output logic             reload_o,
    output logic             tc_o,
    output logic             done_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] base;
        logic             autoinit;
        logic             tc;
        logic             done;
    } ccnt_t;

    ccnt_t st_d, st_q;
    logic  at_zero;

    assign at_zero  = (st_q.cnt == '0);
    assign accept_o = xfer_i && !load_i && !st_q.done;
    assign reload_o = accept_o && at_zero && st_q.autoinit;

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        if (load_i) begin
            st_d.cnt      = load_count_i;
            st_d.base     = load_count_i;
            st_d.autoinit = load_auto_i;
            st_d.done     = 1'b0;
        end else if (accept_o) begin
            if (at_zero) begin
                st_d.tc = 1'b1;
                if (st_q.autoinit) begin
                    st_d.cnt = st_q.base;
                end else begin
                    st_d.cnt  = st_q.cnt - 1'b1;
                    st_d.done = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign tc_o    = st_q.tc;
    assign done_o  = st_q.done;

    // R6: every terminal-count pulse follows an accepted strobe at zero
    a_r6_tc_source: assert property (@(posedge clk) disable iff (!rst_n)
        tc_o |-> ($past(xfer_i) && !$past(load_i) && $past(count_o) == '0));
    // R7: a finished channel keeps its count frozen until a load
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !load_i) |=> ($stable(count_o) && !tc_o));
endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
    import dma_pag_pkg::*;
#(
    parameter int unsigned PAGE_W = DMA_PAGE_W,
    parameter int unsigned CNT_W  = DMA_CNT_W,
    localparam int unsigned ADDR_W = PAGE_W + CNT_W,
    localparam int unsigned RES_W  = CNT_W + 2
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [CNT_W-1:0]  addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              word_i,
    input  logic              done_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [RES_W-1:0]  residue_o
);
    logic [CNT_W:0] xfers_left;

    always_comb begin
        if (word_i) begin
            bus_addr_o = {page_i[PAGE_W-1:1], addr_i, 1'b0};
        end else begin
            bus_addr_o = {page_i, addr_i};
        end
    end

    always_comb begin
        xfers_left = {1'b0, count_i} + 1'b1;
        if (done_i) begin
            residue_o = '0;
        end else if (word_i) begin
            residue_o = {xfers_left, 1'b0};
        end else begin
            residue_o = {1'b0, xfers_left};
        end
    end
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
    import dma_pag_pkg::*;
#(
    parameter int unsigned PAGE_W = DMA_PAGE_W,
    parameter int unsigned CNT_W  = DMA_CNT_W,
    localparam int unsigned ADDR_W = PAGE_W + CNT_W,
    localparam int unsigned RES_W  = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PAGE_W-1:0] load_page_i,
    input  logic [CNT_W-1:0]  load_addr_i,
    input  logic [CNT_W-1:0]  load_count_i,
    input  logic              load_word_i,
    input  logic              load_down_i,
    input  logic              load_auto_i,
    input  logic              xfer_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [RES_W-1:0]  residue_o,
    output logic              tc_o,
    output logic              done_o
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        xfer_width_e       width;
    } chan_t;

    chan_t st_d, st_q;

    logic             accept;
    logic             reload;
    logic [CNT_W-1:0] cur_addr;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.page  = load_page_i;
            st_d.width = xfer_width_e'(load_word_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{page: '0, width: XW_BYTE};
        end else begin
            st_q <= st_d;
        end
    end

    dma_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .load_count_i (load_count_i),
        .load_auto_i  (load_auto_i),
        .xfer_i       (xfer_i),
        .count_o      (count_o),
        .accept_o     (accept),
        .reload_o     (reload),
        .tc_o         (tc_o),
        .done_o       (done_o)
    );

    dma_addr_counter #(.CNT_W(CNT_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .load_addr_i (load_addr_i),
        .load_down_i (load_down_i),
        .step_i      (accept),
        .reload_i    (reload),
        .addr_o      (cur_addr)
    );

    dma_xlate #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_xlate (
        .page_i     (st_q.page),
        .addr_i     (cur_addr),
        .count_i    (count_o),
        .word_i     (st_q.width == XW_WORD),
        .done_i     (done_o),
        .bus_addr_o (bus_addr_o),
        .residue_o  (residue_o)
    );

    // R5: page bits of the bus address never move during strobes
    a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !load_i) |=> $stable(bus_addr_o[ADDR_W-1:CNT_W+1]));
    // R9: a load clears both status flags
    a_r9_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!tc_o && !done_o));
    // R10: nothing left to move once finished
    a_r10_residue_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> residue_o == '0);
endmodule

// File: tb/dma_page_addr_gen_tb.sv
module dma_page_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [7:0]  load_page_i = '0;
    logic [15:0] load_addr_i = '0;
    logic [15:0] load_count_i = '0;
    logic        load_word_i = 1'b0;
    logic        load_down_i = 1'b0;
    logic        load_auto_i = 1'b0;
    logic        xfer_i = 1'b0;
    logic [23:0] bus_addr_o;
    logic [15:0] count_o;
    logic [17:0] residue_o;
    logic        tc_o;
    logic        done_o;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_page_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_page_i(load_page_i),
        .load_addr_i(load_addr_i), .load_count_i(load_count_i),
        .load_word_i(load_word_i), .load_down_i(load_down_i),
        .load_auto_i(load_auto_i), .xfer_i(xfer_i), .bus_addr_o(bus_addr_o),
        .count_o(count_o), .residue_o(residue_o), .tc_o(tc_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [7:0]  page;
        logic [15:0] addr;
        logic [15:0] cnt;
        logic        word;
        logic        down;
        logic        autoi;
        logic [7:0]  nstb;
        logic [23:0] e_bus;
        logic [15:0] e_cnt;
        logic        e_done;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h12, 16'h1234, 16'h0010, 1'b0, 1'b0, 1'b0, 8'd3, 24'h121237, 16'h000D, 1'b0}, // R2 R4
        '{8'h35, 16'h4000, 16'h0005, 1'b1, 1'b0, 1'b0, 8'd2, 24'h348004, 16'h0003, 1'b0}, // R3
        '{8'h7F, 16'h0002, 16'h0009, 1'b0, 1'b1, 1'b0, 8'd4, 24'h7FFFFE, 16'h0005, 1'b0}, // R4 R5 down wrap
        '{8'h01, 16'hFFFE, 16'h0008, 1'b0, 1'b0, 1'b0, 8'd3, 24'h010001, 16'h0005, 1'b0}, // R5 up wrap
        '{8'hFF, 16'hFFFF, 16'h0003, 1'b1, 1'b0, 1'b0, 8'd1, 24'hFE0000, 16'h0002, 1'b0}, // R3 R5 word wrap
        '{8'h00, 16'h0100, 16'h0002, 1'b0, 1'b0, 1'b0, 8'd5, 24'h000103, 16'hFFFF, 1'b1}, // R7
        '{8'h02, 16'h0200, 16'h0001, 1'b0, 1'b0, 1'b1, 8'd3, 24'h020201, 16'h0000, 1'b0}, // R8
        '{8'h10, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 8'd2, 24'h100000, 16'h0000, 1'b0}  // R8 word
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] pg, input logic [15:0] ad, input logic [15:0] cn,
                           input logic wd, input logic dn, input logic au);
        @(negedge clk);
        load_i = 1'b1; load_page_i = pg; load_addr_i = ad; load_count_i = cn;
        load_word_i = wd; load_down_i = dn; load_auto_i = au;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic strobes(input int n);
        xfer_i = 1'b1;
        repeat (n) @(negedge clk);
        xfer_i = 1'b0;
    endtask

    function automatic logic [31:0] exp_res(input logic [15:0] c, input logic w, input logic d);
        logic [31:0] t;
        t = 32'(c) + 32'd1;
        if (d) return 32'd0;
        return w ? (t << 1) : t;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [23:0] held_bus;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 bus", 32'(bus_addr_o), 32'h0);
        check("R1 count", 32'(count_o), 32'h0);
        check("R1 tc", 32'(tc_o), 32'h0);
        check("R1 done", 32'(done_o), 32'h0);
        check("R1 residue", 32'(residue_o), 32'h1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].page, VECS[i].addr, VECS[i].cnt, VECS[i].word,
                    VECS[i].down, VECS[i].autoi);
            strobes(int'(VECS[i].nstb));
            check($sformatf("R2/R3/R4/R5 vec%0d bus", i), 32'(bus_addr_o), 32'(VECS[i].e_bus));
            check($sformatf("R6 vec%0d count", i), 32'(count_o), 32'(VECS[i].e_cnt));
            check($sformatf("R7/R8 vec%0d done", i), 32'(done_o), 32'(VECS[i].e_done));
            check($sformatf("R10 vec%0d residue", i), 32'(residue_o),
                  exp_res(VECS[i].e_cnt, VECS[i].word, VECS[i].e_done));
        end

        // R6 terminal-count pulse timing
        do_load(8'h05, 16'h0010, 16'h0001, 1'b0, 1'b0, 1'b0);
        strobes(1);
        check("R6 no tc before zero", 32'(tc_o), 32'h0);
        strobes(1);
        check("R6 tc pulse", 32'(tc_o), 32'h1);
        check("R7 done set", 32'(done_o), 32'h1);
        check("R7 count wrapped", 32'(count_o), 32'hFFFF);
        @(negedge clk);
        check("R6 tc one cycle", 32'(tc_o), 32'h0);
        // R7 ignored strobes
        held_bus = bus_addr_o;
        strobes(3);
        check("R7 bus frozen", 32'(bus_addr_o), 32'(held_bus));
        check("R7 count frozen", 32'(count_o), 32'hFFFF);
        check("R7 no tc", 32'(tc_o), 32'h0);

        // R9 load clears done, load wins over strobe
        @(negedge clk);
        load_i = 1'b1; xfer_i = 1'b1; load_page_i = 8'hA0; load_addr_i = 16'h0800;
        load_count_i = 16'h0004; load_word_i = 1'b0; load_down_i = 1'b0; load_auto_i = 1'b0;
        @(negedge clk);
        load_i = 1'b0; xfer_i = 1'b0;
        check("R9 done cleared", 32'(done_o), 32'h0);
        check("R9 count loaded", 32'(count_o), 32'h0004);
        check("R9 bus loaded", 32'(bus_addr_o), 32'hA00800);

        // R10 full-count residue scaling
        do_load(8'h00, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 1'b0);
        check("R10 word full residue", 32'(residue_o), 32'h20000);
        do_load(8'h00, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0);
        check("R10 byte full residue", 32'(residue_o), 32'h10000);

        // R8 autoinit terminal count
        do_load(8'h00, 16'h0050, 16'h0000, 1'b0, 1'b0, 1'b1);
        strobes(1);
        check("R8 tc pulse", 32'(tc_o), 32'h1);
        check("R8 done low", 32'(done_o), 32'h0);
        check("R8 bus reloaded", 32'(bus_addr_o), 32'h000050);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule